// File: doc/BRIEF.md
# Packed Four-Lane Image Cross-Fade Unit

This unit mixes two images into one by a weighted average. Each input word carries four 8-bit samples of one colour plane taken from image A. A second word carries the four samples of the same plane taken from image B. A 16-bit signed fade factor is applied to all four lanes alike. Each output sample approximates `fade*A + (1-fade)*B`. The unit computes this with a single multiply per lane, `fade*(A-B) + B`, so it never needs one multiply for A and a second for B.

Inside, each byte is widened to a 16-bit lane. The lanes then pass through the following steps in order:
- B is subtracted from A.
- The difference is doubled.
- It is multiplied by the fade factor, and only the upper half of the 32-bit product is kept.
- B is added back.
- The result is clamped into one byte.

A fade of 0x7FFF stands for almost 1.0 and a fade of 0x0000 stands for 0. The datapath is split over two register stages. A word accepted with `in_valid` comes back with `out_valid` a fixed two clocks later, and a new word can be accepted on every clock.

Top module: `xfade_simd`

## Requirements
- R1: A word sampled with `in_valid` high at rising edge k appears on `pix_out` with `out_valid` high after rising edge k+1. That is the second register stage, so the latency is two clocks. `out_valid` is low in every cycle that has no such word.
- R2: While `rst` is high at a rising edge, `out_valid` and `pix_out` are cleared to zero at that edge.
- R3: Lane i occupies bits [8i+7:8i] of `pix_a`, `pix_b` and `pix_out`, for i = 0 to 3. Each output lane depends only on the same lane of A and B and on the fade.
- R4: With `fade` read as a signed two's-complement value f, each output lane equals clamp(b + floor(2*(a-b)*f / 65536)). The clamp is to [0,255], and a and b are the unsigned lane bytes.
- R5: A fade of 0x0000 returns B unchanged in every lane.
- R6: For any fade from 0x0000 to 0x7FFF, each output lane lies between that lane's A and B values, inclusive. A fade of 0x7FFF with A = 255 and B = 0 gives 254, and with A = 0 and B = 255 it gives 0.
- R7: Lane sums above 255 saturate to 255 and sums below 0 saturate to 0. Such sums are reachable with negative fades such as 0x8000.
- R8: While `out_valid` is low, `pix_out` keeps the last result it delivered, or zero if there has been none since reset.
- R9: With `in_valid` high on consecutive clocks, one correct result per clock emerges in the order the words were given.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word qualifier |
| pix_a | input | 32 | Four 8-bit samples of image A, one plane |
| pix_b | input | 32 | Four 8-bit samples of image B, same plane |
| fade | input | 16 | Signed fade factor, 0x7FFF close to 1.0 |
| out_valid | output | 1 | Result qualifier, two clocks after input |
| pix_out | output | 32 | Four blended and clamped 8-bit samples |

## Verification
The checker assumes that `in_valid`, `pix_a`, `pix_b` and `fade` are stable around each rising edge and that reset is held for at least two clocks. The betweenness property is enabled only when the fade lies in the non-negative range. Outside that range, saturation rather than interpolation is the expected behaviour, so the bench applies negative fades only in the saturation scenario. The bench drives every input on the falling edge and reads every output on the falling edge. It keeps its own expected-value pipeline computed from the lane formula, so streaming, idle gaps and isolated words are all compared against the model at the exact cycle the result is due.

// File: rtl/xfade_pkg.sv
package xfade_pkg;

    localparam int unsigned PIX_W   = 8;
    localparam int unsigned LANE_W  = 16;
    localparam int unsigned PROD_W  = 2 * LANE_W;
    localparam int unsigned SUM_W   = LANE_W + 1;
    localparam int unsigned PIX_MAX = (1 << PIX_W) - 1;

    typedef logic [PIX_W-1:0]         pix_t;
    typedef logic signed [LANE_W-1:0] lane_t;
    typedef logic signed [SUM_W-1:0]  sum_t;

    // Per-lane state after the first stage: doubled difference and base sample.
    typedef struct packed {
        lane_t diff2;
        lane_t base;
    } front_lane_t;

    // Zero-extend one byte into a 16-bit lane.
    function automatic lane_t widen(input pix_t p);
        return lane_t'({{(LANE_W-PIX_W){1'b0}}, p});
    endfunction

    // Clamp a signed lane sum into an unsigned byte.
    function automatic pix_t clamp_byte(input sum_t v);
        if (v[SUM_W-1])
            return '0;
        else if (v > sum_t'(PIX_MAX))
            return pix_t'(PIX_MAX);
        else
            return v[PIX_W-1:0];
    endfunction

endpackage

// File: rtl/xfade_front.sv
module xfade_front
    import xfade_pkg::*;
#(
    parameter int unsigned LANES = 4,
    localparam int unsigned WORD_W = LANES * PIX_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [WORD_W-1:0]         pix_a,
    input  logic [WORD_W-1:0]         pix_b,
    input  logic [LANE_W-1:0]         fade,
    output logic                      s1_valid,
    output front_lane_t [LANES-1:0]   s1_lanes,
    output lane_t                     s1_fade
);

    front_lane_t [LANES-1:0] lanes_d;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        lane_t a_w;
        lane_t b_w;
        lane_t d_w;
        assign a_w = widen(pix_a[i*PIX_W +: PIX_W]);
        assign b_w = widen(pix_b[i*PIX_W +: PIX_W]);
        assign d_w = a_w - b_w;
        assign lanes_d[i].diff2 = d_w <<< 1;
        assign lanes_d[i].base  = b_w;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_lanes <= '0;
            s1_fade  <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_lanes <= lanes_d;
                s1_fade  <= lane_t'(fade);
            end
        end
    end

endmodule

// File: rtl/xfade_lane_mac.sv
module xfade_lane_mac
    import xfade_pkg::*;
(
    input  front_lane_t lane_in,
    input  lane_t       fade_in,
    output pix_t        pix_res
);

    logic signed [PROD_W-1:0] prod;
    lane_t                    prod_hi;
    sum_t                     sum;

    assign prod    = PROD_W'(lane_in.diff2) * PROD_W'(fade_in);
    assign prod_hi = prod[PROD_W-1:LANE_W];
    assign sum     = SUM_W'(prod_hi) + SUM_W'(lane_in.base);
    assign pix_res = clamp_byte(sum);

endmodule

// File: rtl/xfade_back.sv
module xfade_back
    import xfade_pkg::*;
#(
    parameter int unsigned LANES = 4,
    localparam int unsigned WORD_W = LANES * PIX_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      s1_valid,
    input  front_lane_t [LANES-1:0]   s1_lanes,
    input  lane_t                     s1_fade,
    output logic                      out_valid,
    output logic [WORD_W-1:0]         pix_out
);

    logic [WORD_W-1:0] packed_d;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        xfade_lane_mac mac_i (
            .lane_in (s1_lanes[i]),
            .fade_in (s1_fade),
            .pix_res (packed_d[i*PIX_W +: PIX_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            pix_out   <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid)
                pix_out <= packed_d;
        end
    end

endmodule

// File: rtl/xfade_simd.sv
module xfade_simd
    import xfade_pkg::*;
#(
    parameter int unsigned LANES = 4,
    localparam int unsigned WORD_W = LANES * PIX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] pix_a,
    input  logic [WORD_W-1:0] pix_b,
    input  logic [LANE_W-1:0] fade,
    output logic              out_valid,
    output logic [WORD_W-1:0] pix_out
);

    logic                    s1_valid;
    front_lane_t [LANES-1:0] s1_lanes;
    lane_t                   s1_fade;

    xfade_front #(.LANES(LANES)) front_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .pix_a    (pix_a),
        .pix_b    (pix_b),
        .fade     (fade),
        .s1_valid (s1_valid),
        .s1_lanes (s1_lanes),
        .s1_fade  (s1_fade)
    );

    xfade_back #(.LANES(LANES)) back_i (
        .clk       (clk),
        .rst       (rst),
        .s1_valid  (s1_valid),
        .s1_lanes  (s1_lanes),
        .s1_fade   (s1_fade),
        .out_valid (out_valid),
        .pix_out   (pix_out)
    );

endmodule

// File: rtl/xfade_simd_chk.sv
module xfade_simd_chk
    import xfade_pkg::*;
#(
    parameter int unsigned LANES = 4,
    localparam int unsigned WORD_W = LANES * PIX_W
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [WORD_W-1:0] pix_a,
    input logic [WORD_W-1:0] pix_b,
    input logic [LANE_W-1:0] fade,
    input logic              out_valid,
    input logic [WORD_W-1:0] pix_out
);

    logic              v1, v2;
    logic [WORD_W-1:0] a1, a2, b1, b2;
    logic [LANE_W-1:0] f1, f2;
    logic              between_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            v1 <= 1'b0; v2 <= 1'b0;
            a1 <= '0;   a2 <= '0;
            b1 <= '0;   b2 <= '0;
            f1 <= '0;   f2 <= '0;
        end else begin
            v1 <= in_valid; v2 <= v1;
            a1 <= pix_a;    a2 <= a1;
            b1 <= pix_b;    b2 <= b1;
            f1 <= fade;     f2 <= f1;
        end
    end

    always_comb begin
        between_ok = 1'b1;
        for (int i = 0; i < LANES; i++) begin
            if (pix_out[i*PIX_W +: PIX_W] < a2[i*PIX_W +: PIX_W] &&
                pix_out[i*PIX_W +: PIX_W] < b2[i*PIX_W +: PIX_W])
                between_ok = 1'b0;
            if (pix_out[i*PIX_W +: PIX_W] > a2[i*PIX_W +: PIX_W] &&
                pix_out[i*PIX_W +: PIX_W] > b2[i*PIX_W +: PIX_W])
                between_ok = 1'b0;
        end
    end

    // R1
    latency_match_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid == v2);

    // R2
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && pix_out == '0));

    // R5
    zero_fade_chk: assert property (@(posedge clk) disable iff (rst)
        (v2 && f2 == '0) |-> pix_out == b2);

    // R6
    between_chk: assert property (@(posedge clk) disable iff (rst)
        (v2 && !f2[LANE_W-1]) |-> between_ok);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(pix_out));

endmodule

bind xfade_simd xfade_simd_chk #(.LANES(LANES)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .pix_a     (pix_a),
    .pix_b     (pix_b),
    .fade      (fade),
    .out_valid (out_valid),
    .pix_out   (pix_out)
);

// File: tb/xfade_simd_tb.sv
module xfade_simd_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] pix_a = '0;
    logic [31:0] pix_b = '0;
    logic [15:0] fade = '0;
    logic        out_valid;
    logic [31:0] pix_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    logic        ev0 = 1'b0, ev1 = 1'b0;
    logic [31:0] ex0 = '0, ex1 = '0;
    string       tg0 = "", tg1 = "";
    logic [31:0] last_out = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xfade_simd dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .pix_a     (pix_a),
        .pix_b     (pix_b),
        .fade      (fade),
        .out_valid (out_valid),
        .pix_out   (pix_out)
    );

    function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic [15:0] f);
        logic [31:0] r = '0;
        for (int i = 0; i < 4; i++) begin
            int av = int'(a[i*8 +: 8]);
            int bv = int'(b[i*8 +: 8]);
            int p  = 2 * (av - bv) * int'($signed(f));
            int s  = bv + (p >>> 16);
            if (s < 0) s = 0;
            if (s > 255) s = 255;
            r[i*8 +: 8] = 8'(s);
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: check the output due now, then drive the next input.
    task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b,
                        input logic [15:0] f, input string tag);
        @(negedge clk);
        if (ev1) begin
            check(out_valid === 1'b1, {tg1, " out_valid"}, 32'(out_valid), 32'd1);
            check(pix_out === ex1, {tg1, " pix_out"}, pix_out, ex1);
            last_out = ex1;
        end else begin
            check(out_valid === 1'b0, "R1 idle out_valid", 32'(out_valid), 32'd0);
            check(pix_out === last_out, "R8 idle hold", pix_out, last_out);
        end
        ev1 = ev0; ex1 = ex0; tg1 = tg0;
        ev0 = v;   ex0 = model(a, b, f); tg0 = tag;
        in_valid = v; pix_a = a; pix_b = b; fade = f;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0, '0, '0, "idle");
    endtask

    task automatic t_reset;
        repeat (3) begin
            @(negedge clk);
            check(out_valid === 1'b0, "R2 reset out_valid", 32'(out_valid), 32'd0);
            check(pix_out === '0, "R2 reset pix_out", pix_out, 32'd0);
        end
        rst = 1'b0;
    endtask

    task automatic t_latency;
        step(1'b1, 32'h10203040, 32'h08070605, 16'h4000, "R1");
        idle(3);
    endtask

    task automatic t_fade_zero;
        step(1'b1, 32'hFF00FF00, 32'h12345678, 16'h0000, "R5");
        step(1'b1, 32'h00000000, 32'hFFFFFFFF, 16'h0000, "R5");
        step(1'b1, 32'hA5A5A5A5, 32'h5A5A5A5A, 16'h0000, "R5");
        idle(2);
    endtask

    task automatic t_full;
        step(1'b1, 32'h000000FF, 32'h00000000, 16'h7FFF, "R6");
        step(1'b1, 32'h00000000, 32'h000000FF, 16'h7FFF, "R6");
        step(1'b1, 32'h3C3C3C3C, 32'h3C3C3C3C, 16'h7FFF, "R6");
        step(1'b1, 32'hC80A64FF, 32'h14F03200, 16'h5555, "R6");
        idle(2);
    endtask

    task automatic t_lanes;
        step(1'b1, 32'h00C80000, 32'h00000000, 16'h4000, "R3");
        step(1'b1, 32'h000000FF, 32'hFF000000, 16'h2000, "R3");
        step(1'b1, 32'h01020304, 32'hF0E0D0C0, 16'h6000, "R3");
        idle(2);
    endtask

    task automatic t_formula;
        for (int i = 0; i < 24; i++) begin
            logic [31:0] a = 32'(i * 32'h1F3D5B79 + 32'h13579BDF);
            logic [31:0] b = 32'(i * 32'h2468ACE1 + 32'h0F1E2D3C);
            logic [15:0] f = 16'((i * 1423) & 16'h7FFF);
            step(1'b1, a, b, f, "R4");
            if (i % 5 == 4) idle(1);
        end
        idle(2);
    endtask

    task automatic t_sat;
        step(1'b1, 32'h00000000, 32'h000000C8, 16'h8000, "R7");
        step(1'b1, 32'h000000C8, 32'h00000000, 16'h8000, "R7");
        step(1'b1, 32'h10F02080, 32'hF0109040, 16'hC000, "R7");
        idle(2);
    endtask

    task automatic t_stream;
        for (int i = 0; i < 32; i++) begin
            logic [31:0] a = 32'(i * 32'h01010101 + 32'h40302010);
            logic [31:0] b = 32'(32'hFFFFFFFF - i * 32'h03050709);
            logic [15:0] f = 16'(i * 1021);
            step(1'b1, a, b, f, "R9");
        end
        idle(2);
    endtask

    task automatic t_hold;
        step(1'b1, 32'h80808080, 32'h20202020, 16'h3000, "R8");
        idle(4);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_fade_zero();
        t_full();
        t_lanes();
        t_formula();
        t_sat();
        t_stream();
        t_hold();
        idle(2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule